// File: doc/BRIEF.md
# Reloadable Timer with Toggle Output

This block is a down-counting timer with a reload latch, driven from a fixed clock prescaler. While the timer runs, every sixteenth clock is a count tick, and each tick lowers the counter by one. The first tick that finds the counter already at zero is an underflow. On that tick the counter takes the latch value again, so the underflow period is (reload + 1) × 16 clocks. After reset the timer counts without any setup, because the halt bit resets to 0.

The block can also drive a square wave. In pulse mode the output starts at a level that software picks and inverts on every underflow. There are two interrupt request flags, each with its own enable. One flag is set on every underflow. The other is set when the output makes the edge that the level-select bit chooses. Software uses a small write/read register port to load the latch, halt and restart the timer, pick the mode, and clear the flags.

Top module: `reload_toggle_timer`

## Requirements
- R1: After reset: halt is 0, the counter and the reload latch hold all ones, both flags and all control bits are 0, pulse_out and pulse_oe are 0, and rd_data is 0. Counting starts as soon as reset is released.
- R2: While the timer runs, a count tick occurs every 16 clocks, and the counter falls by one on each tick.
  - The first tick falls on the 16th clock edge after reset release. After a restart (a control write that changes halt from 1 to 0), it falls 16 edges after that write edge.
- R3: A tick that finds the counter at 0x00 is an underflow. On that same edge the counter loads the reload latch, so underflows repeat every (reload + 1) × 16 clocks.
- R4: While halt (control bit 0) is 1, the counter does not change and no underflow occurs.
- R5: A write to the reload latch (address 0) while the timer is halted also loads the counter. While the timer runs, the write changes only the latch, and the counter takes the new value at the next underflow.
- R6: A control write that turns pulse mode on (control bit 1 goes from 0 to 1) sets pulse_out to the level-select value (control bit 2) and sets pulse_oe to 1 on that edge. This setup takes priority over a toggle on the same edge.
- R7: In pulse mode, pulse_out inverts on every underflow and holds between underflows. A control write that turns pulse mode off drives pulse_out and pulse_oe to 0.
- R8: Every underflow sets the underflow flag (flag bit 0). irq_underflow is that flag ANDed with the underflow enable (control bit 3).
- R9: In pulse mode, an underflow toggle sets the edge flag (flag bit 1) when it produces the selected edge.
  - Level select 0 selects the rising edge (start low). Level select 1 selects the falling edge (start high).
  - irq_edge is the edge flag ANDed with the edge enable (control bit 4).
- R10: A write to the flags (address 3) clears each flag whose data bit is 0 and leaves unchanged each flag whose data bit is 1. A set event on the same edge as a clear wins.
- R11: Register map.
  - Reads: address 0 returns the latch, address 1 the counter, address 2 the five control bits, and address 3 the two flags.
  - Writes to address 1 are ignored.
  - rd_data holds the value selected on the edge where rd_en was high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Write address (0 latch, 1 counter, 2 control, 3 flags) |
| wr_data | input | CNT_W | Write data |
| rd_en | input | 1 | Register read strobe |
| rd_addr | input | 2 | Read address |
| rd_data | output | CNT_W | Registered read data |
| pulse_out | output | 1 | Toggle output level |
| pulse_oe | output | 1 | High while pulse mode is selected |
| irq_underflow | output | 1 | Gated underflow interrupt request |
| irq_edge | output | 1 | Gated output-edge interrupt request |

## Verification
Every result is due at a fixed edge, and the bench works out that edge before it samples.

| Event | Result is visible |
|---|---|
| Start from a halted state | First underflow, output toggle and flag set come exactly 16 × (reload + 1) edges after the control write that starts the timer |
| Control, latch or flag write | Effect shows on the write edge itself |
| Read | rd_data shows the value from the edge where rd_en was high |

The bench drives and samples on the falling clock edge and counts rising edges from a known write edge. It then compares the toggle intervals against the arithmetic period over a sweep of reload values. It also checks a tick-by-tick counter trace and a clear that is timed to land on an underflow edge.

// File: rtl/rtt_pkg.sv
package rtt_pkg;

  typedef enum logic [1:0] {
    RA_RELOAD = 2'd0,
    RA_COUNT  = 2'd1,
    RA_CTRL   = 2'd2,
    RA_FLAGS  = 2'd3
  } rtt_addr_e;

  // halt is bit 0 ... edge_en is bit 4
  typedef struct packed {
    logic edge_en;
    logic uf_en;
    logic sel;
    logic pulse;
    logic halt;
  } rtt_ctrl_t;

  localparam int CTRL_BITS = $bits(rtt_ctrl_t);
  localparam int NUM_FLAGS = 2;
  localparam int FLAG_UF   = 0;
  localparam int FLAG_EDGE = 1;

endpackage

// File: rtl/rtt_prescaler.sv
module rtt_prescaler #(
  parameter int DIV = 16
) (
  input  logic clk,
  input  logic rst,
  input  logic halt,
  output logic tick
);
  localparam int PW = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [PW-1:0] LAST = PW'(DIV - 1);

  logic [PW-1:0] ph_q;

  // held at zero while halted, so a restart always begins a full period
  always_ff @(posedge clk) begin
    if (rst || halt) begin
      ph_q <= '0;
    end else if (ph_q == LAST) begin
      ph_q <= '0;
    end else begin
      ph_q <= ph_q + 1'b1;
    end
  end

  assign tick = !halt && (ph_q == LAST);

  // R2: prescaler phase is parked at zero while halted
  a_r2_parked_when_halted: assert property (@(posedge clk) disable iff (rst)
    halt |=> (ph_q == '0));

  // R2: a tick starts a fresh period
  a_r2_wrap_after_tick: assert property (@(posedge clk) disable iff (rst)
    tick |=> (ph_q == '0));

endmodule

// File: rtl/rtt_downcounter.sv
module rtt_downcounter #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         tick,
  input  logic         halt,
  input  logic         latch_we,
  input  logic [W-1:0] latch_wdata,
  output logic [W-1:0] cnt_q,
  output logic [W-1:0] latch_q,
  output logic         uf
);
  localparam logic [W-1:0] ALL_ONES = '1;

  assign uf = tick && (cnt_q == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      latch_q <= ALL_ONES;
      cnt_q   <= ALL_ONES;
    end else begin
      if (latch_we) begin
        latch_q <= latch_wdata;
      end
      if (tick) begin
        if (cnt_q == '0) begin
          cnt_q <= latch_q;
        end else begin
          cnt_q <= cnt_q - 1'b1;
        end
      end else if (latch_we && halt) begin
        cnt_q <= latch_wdata;
      end
    end
  end

  // R3: underflow reloads from the latch value present before the edge
  a_r3_reload_on_underflow: assert property (@(posedge clk) disable iff (rst)
    uf |=> (cnt_q == $past(latch_q)));

  // R2: non-zero tick steps down by one
  a_r2_step_down: assert property (@(posedge clk) disable iff (rst)
    (tick && (cnt_q != '0)) |=> (cnt_q == W'($past(cnt_q) - 1'b1)));

  // R4: halted counter only moves on a direct load
  a_r4_frozen_when_halted: assert property (@(posedge clk) disable iff (rst)
    (halt && !latch_we) |=> $stable(cnt_q));

  // R5: halted latch write loads the counter
  a_r5_direct_load: assert property (@(posedge clk) disable iff (rst)
    (halt && latch_we) |=> (cnt_q == $past(latch_wdata)));

  // R5: running latch write leaves the counter alone off-tick
  a_r5_latch_only: assert property (@(posedge clk) disable iff (rst)
    (!halt && latch_we && !tick) |=> $stable(cnt_q));

  // R4: no tick while halted
  a_r4_no_tick_halted: assert property (@(posedge clk) disable iff (rst)
    halt |-> !tick);

endmodule

// File: rtl/rtt_pulse_gen.sv
module rtt_pulse_gen (
  input  logic clk,
  input  logic rst,
  input  logic mode,
  input  logic sel,
  input  logic enter,
  input  logic leave,
  input  logic start_lvl,
  input  logic uf,
  output logic pulse_q,
  output logic edge_evt
);
  logic toggle;

  assign toggle   = mode && uf && !enter && !leave;
  // rising wanted when sel=0 (level now low), falling when sel=1 (level now high)
  assign edge_evt = toggle && (pulse_q == sel);

  always_ff @(posedge clk) begin
    if (rst) begin
      pulse_q <= 1'b0;
    end else if (enter) begin
      pulse_q <= start_lvl;
    end else if (leave) begin
      pulse_q <= 1'b0;
    end else if (toggle) begin
      pulse_q <= ~pulse_q;
    end
  end

  // R6: entering pulse mode sets the start level
  a_r6_start_level: assert property (@(posedge clk) disable iff (rst)
    enter |=> (pulse_q == $past(start_lvl)));

  // R7: underflow in pulse mode inverts the output
  a_r7_toggle: assert property (@(posedge clk) disable iff (rst)
    (mode && uf && !enter && !leave) |=> (pulse_q != $past(pulse_q)));

  // R7: level holds between underflows
  a_r7_hold: assert property (@(posedge clk) disable iff (rst)
    (!uf && !enter && !leave) |=> $stable(pulse_q));

  // R7: leaving pulse mode drives low
  a_r7_leave_low: assert property (@(posedge clk) disable iff (rst)
    leave |=> !pulse_q);

endmodule

// File: rtl/rtt_req_flags.sv
module rtt_req_flags #(
  parameter int N = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] set,
  input  logic [N-1:0] clr,
  output logic [N-1:0] flag_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      flag_q <= '0;
    end else begin
      for (int i = 0; i < N; i++) begin
        if (set[i]) begin
          flag_q[i] <= 1'b1;
        end else if (clr[i]) begin
          flag_q[i] <= 1'b0;
        end
      end
    end
  end

  for (genvar gi = 0; gi < N; gi++) begin : g_chk
    // R10: set beats a simultaneous clear
    a_r10_set_wins: assert property (@(posedge clk) disable iff (rst)
      set[gi] |=> flag_q[gi]);

    // R10: clear without set drops the flag
    a_r10_clear: assert property (@(posedge clk) disable iff (rst)
      (clr[gi] && !set[gi]) |=> !flag_q[gi]);

    // R10: with neither, the flag holds
    a_r10_hold: assert property (@(posedge clk) disable iff (rst)
      (!clr[gi] && !set[gi]) |=> $stable(flag_q[gi]));
  end

endmodule

// File: rtl/reload_toggle_timer.sv
module reload_toggle_timer
  import rtt_pkg::*;
#(
  parameter int CNT_W     = 8,
  parameter int PRESC_DIV = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [1:0]       wr_addr,
  input  logic [CNT_W-1:0] wr_data,
  input  logic             rd_en,
  input  logic [1:0]       rd_addr,
  output logic [CNT_W-1:0] rd_data,
  output logic             pulse_out,
  output logic             pulse_oe,
  output logic             irq_underflow,
  output logic             irq_edge
);
  rtt_ctrl_t                ctrl_q;
  rtt_ctrl_t                ctrl_new;
  logic                     we_reload;
  logic                     we_ctrl;
  logic                     we_flags;
  logic                     tick;
  logic                     uf;
  logic                     edge_evt;
  logic                     enter;
  logic                     leave;
  logic                     pulse_q;
  logic [CNT_W-1:0]         cnt_q;
  logic [CNT_W-1:0]         latch_q;
  logic [NUM_FLAGS-1:0]     flag_set;
  logic [NUM_FLAGS-1:0]     flag_clr;
  logic [NUM_FLAGS-1:0]     flag_q;
  logic [CNT_W-1:0]         rd_data_q;

  // write decode; the counter address takes no writes
  always_comb begin
    we_reload = 1'b0;
    we_ctrl   = 1'b0;
    we_flags  = 1'b0;
    if (wr_en) begin
      unique case (rtt_addr_e'(wr_addr))
        RA_RELOAD: we_reload = 1'b1;
        RA_CTRL:   we_ctrl   = 1'b1;
        RA_FLAGS:  we_flags  = 1'b1;
        default:   ;
      endcase
    end
  end

  assign ctrl_new = rtt_ctrl_t'(wr_data[CTRL_BITS-1:0]);
  assign enter    = we_ctrl &&  ctrl_new.pulse && !ctrl_q.pulse;
  assign leave    = we_ctrl && !ctrl_new.pulse &&  ctrl_q.pulse;

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q <= '0;
    end else if (we_ctrl) begin
      ctrl_q <= ctrl_new;
    end
  end

  rtt_prescaler #(.DIV(PRESC_DIV)) presc_i (
    .clk  (clk),
    .rst  (rst),
    .halt (ctrl_q.halt),
    .tick (tick)
  );

  rtt_downcounter #(.W(CNT_W)) cnt_i (
    .clk         (clk),
    .rst         (rst),
    .tick        (tick),
    .halt        (ctrl_q.halt),
    .latch_we    (we_reload),
    .latch_wdata (wr_data),
    .cnt_q       (cnt_q),
    .latch_q     (latch_q),
    .uf          (uf)
  );

  rtt_pulse_gen pulse_i (
    .clk       (clk),
    .rst       (rst),
    .mode      (ctrl_q.pulse),
    .sel       (ctrl_q.sel),
    .enter     (enter),
    .leave     (leave),
    .start_lvl (ctrl_new.sel),
    .uf        (uf),
    .pulse_q   (pulse_q),
    .edge_evt  (edge_evt)
  );

  always_comb begin
    flag_set            = '0;
    flag_set[FLAG_UF]   = uf;
    flag_set[FLAG_EDGE] = edge_evt;
    for (int i = 0; i < NUM_FLAGS; i++) begin
      flag_clr[i] = we_flags && !wr_data[i];
    end
  end

  rtt_req_flags #(.N(NUM_FLAGS)) flags_i (
    .clk    (clk),
    .rst    (rst),
    .set    (flag_set),
    .clr    (flag_clr),
    .flag_q (flag_q)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_data_q <= '0;
    end else if (rd_en) begin
      unique case (rtt_addr_e'(rd_addr))
        RA_RELOAD: rd_data_q <= latch_q;
        RA_COUNT:  rd_data_q <= cnt_q;
        RA_CTRL:   rd_data_q <= CNT_W'(ctrl_q);
        RA_FLAGS:  rd_data_q <= CNT_W'(flag_q);
        default:   rd_data_q <= '0;
      endcase
    end
  end

  assign rd_data       = rd_data_q;
  assign pulse_out     = pulse_q;
  assign pulse_oe      = ctrl_q.pulse;
  assign irq_underflow = flag_q[FLAG_UF]   && ctrl_q.uf_en;
  assign irq_edge      = flag_q[FLAG_EDGE] && ctrl_q.edge_en;

  // R8: every underflow leaves the underflow flag set
  a_r8_uf_sets_flag: assert property (@(posedge clk) disable iff (rst)
    uf |=> flag_q[FLAG_UF]);

  // R9: a selected output edge leaves the edge flag set
  a_r9_edge_sets_flag: assert property (@(posedge clk) disable iff (rst)
    edge_evt |=> flag_q[FLAG_EDGE]);

  // R6: output enable follows pulse mode entry
  a_r6_oe_on_enter: assert property (@(posedge clk) disable iff (rst)
    enter |=> pulse_oe);

  // R11: control register captures the written bits
  a_r11_ctrl_store: assert property (@(posedge clk) disable iff (rst)
    we_ctrl |=> (ctrl_q == $past(ctrl_new)));

endmodule

// File: tb/reload_toggle_timer_tb_top.sv
module reload_toggle_timer_tb_top;
  localparam int W = 8;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         wr_en = 1'b0;
  logic [1:0]   wr_addr = '0;
  logic [W-1:0] wr_data = '0;
  logic         rd_en = 1'b0;
  logic [1:0]   rd_addr = '0;
  logic [W-1:0] rd_data;
  logic         pulse_out, pulse_oe, irq_underflow, irq_edge;

  int total = 0;
  int bad   = 0;
  bit done  = 1'b0;

  always #2 clk = ~clk;

  reload_toggle_timer #(.CNT_W(W), .PRESC_DIV(16)) dut_i (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data), .pulse_out(pulse_out),
    .pulse_oe(pulse_oe), .irq_underflow(irq_underflow), .irq_edge(irq_edge)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // called at a falling edge; returns at the falling edge after the write edge
  task automatic wr(input int a, input int d);
    wr_en = 1'b1; wr_addr = 2'(a); wr_data = W'(d);
    @(posedge clk); @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input int a, output int d);
    rd_en = 1'b1; rd_addr = 2'(a);
    @(posedge clk); @(negedge clk);
    d = int'(rd_data);
    rd_en = 1'b0;
  endtask

  // number of rising edges until pulse_out changes
  task automatic edges_to_toggle(output int n);
    logic lvl;
    lvl = pulse_out;
    n = -1;
    for (int k = 1; k <= 5000; k++) begin
      @(posedge clk); @(negedge clk);
      if (pulse_out != lvl) begin
        n = k;
        break;
      end
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      bad++;
      total++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int v, n;
    int lvals[14] = '{0,1,2,3,4,5,6,7,8,9,10,11,12,255};

    // R1 reset state, R2 first tick 16 edges after release
    repeat (4) @(posedge clk);
    @(negedge clk);
    chk(rd_data == 0 && pulse_out == 0 && pulse_oe == 0, "R1 outputs in reset",
        int'({rd_data, pulse_out, pulse_oe}), 0);
    chk(irq_underflow == 0 && irq_edge == 0, "R1 irq in reset", int'({irq_underflow, irq_edge}), 0);
    rst = 1'b0;
    rd_en = 1'b1; rd_addr = 2'd1;
    for (int k = 1; k <= 18; k++) begin
      @(posedge clk); @(negedge clk);
      // rd_data after edge k = counter after edge k-1
      if (k == 16) chk(rd_data == 8'hFF, "R1 counter all ones", int'(rd_data), 255);
      if (k == 18) chk(rd_data == 8'hFE, "R2 first tick at edge 16", int'(rd_data), 254);
    end
    rd_en = 1'b0;
    rd(0, v); chk(v == 255, "R1 latch all ones", v, 255);
    rd(2, v); chk(v == 0, "R1 control zero", v, 0);
    rd(3, v); chk(v == 0, "R1 flags zero", v, 0);

    // R5 halted latch write loads counter; R11 counter address ignores writes
    wr(2, 1);
    wr(0, 8'h2A);
    rd(1, v); chk(v == 8'h2A, "R5 halted load", v, 42);
    wr(1, 8'h55);
    rd(1, v); chk(v == 8'h2A, "R11 count write ignored", v, 42);
    rd(0, v); chk(v == 8'h2A, "R11 latch readback", v, 42);
    rd(2, v); chk(v == 1, "R11 control readback", v, 1);

    // R2 tick-by-tick trace after restart
    wr(0, 16);
    wr(2, 0);
    rd_en = 1'b1; rd_addr = 2'd1;
    begin
      int errs = 0;
      for (int k = 1; k <= 40; k++) begin
        @(posedge clk); @(negedge clk);
        if (int'(rd_data) != 16 - (k - 1) / 16) errs++;
      end
      chk(errs == 0, "R2 restart trace mismatches", errs, 0);
    end
    rd_en = 1'b0;

    // R4 halt freezes counter and blocks underflow
    wr(0, 0);
    wr(2, 8'h09);
    wr(3, 0);
    rd(1, v);
    repeat (100) @(negedge clk);
    rd(1, n);
    chk(n == v, "R4 counter frozen", n, v);
    chk(irq_underflow == 0, "R4 no underflow while halted", int'(irq_underflow), 0);

    // R3 R6 R7 R8 R9 sweep over reload values, level select 0
    foreach (lvals[i]) begin
      int lv = lvals[i];
      wr(2, 1);
      wr(0, lv);
      wr(3, 0);
      wr(2, 8'h1A);
      chk(pulse_out == 0 && pulse_oe == 1, "R6 start low", int'({pulse_out, pulse_oe}), 1);
      edges_to_toggle(n);
      chk(n == 16 * (lv + 1), "R3 first period", n, 16 * (lv + 1));
      chk(irq_underflow == 1, "R8 underflow flag", int'(irq_underflow), 1);
      chk(irq_edge == 1, "R9 rising edge selected", int'(irq_edge), 1);
      edges_to_toggle(n);
      chk(n == 16 * (lv + 1), "R7 toggle period", n, 16 * (lv + 1));
    end

    // R9 level select 1: start high, falling counted, rising not
    wr(2, 1);
    wr(0, 0);
    wr(3, 0);
    wr(2, 8'h16);
    chk(pulse_out == 1, "R6 start high", int'(pulse_out), 1);
    edges_to_toggle(n);
    chk(n == 16 && irq_edge == 1, "R9 falling edge selected", int'(irq_edge), 1);
    wr(3, 8'h03);
    chk(irq_edge == 1, "R10 write one keeps flag", int'(irq_edge), 1);
    wr(3, 0);
    chk(irq_edge == 0, "R10 write zero clears", int'(irq_edge), 0);
    edges_to_toggle(n);
    chk(n == 14 && irq_edge == 0, "R9 rising not selected", int'(irq_edge), 0);
    wr(2, 8'h05);
    chk(pulse_out == 0 && pulse_oe == 0, "R7 leave drives low", int'({pulse_out, pulse_oe}), 0);

    // R5 running latch write takes effect at next underflow
    wr(2, 1);
    wr(0, 3);
    wr(2, 8'h02);
    edges_to_toggle(n);
    chk(n == 64, "R5 period with old latch", n, 64);
    wr(0, 1);
    edges_to_toggle(n);
    chk(n == 63, "R5 running write not immediate", n, 63);
    edges_to_toggle(n);
    chk(n == 32, "R5 new latch after underflow", n, 32);

    // R10 set on the same edge as a clear wins
    wr(2, 1);
    wr(0, 0);
    wr(3, 0);
    wr(2, 8'h08);
    repeat (15) @(posedge clk);
    @(negedge clk);
    wr(3, 0);
    chk(irq_underflow == 1, "R10 set wins over clear", int'(irq_underflow), 1);
    wr(3, 0);
    chk(irq_underflow == 0, "R10 clear off underflow", int'(irq_underflow), 0);
    wr(2, 8'h00);
    repeat (20) @(negedge clk);
    chk(irq_underflow == 0, "R8 enable gates request", int'(irq_underflow), 0);
    rd(3, v);
    chk((v & 1) == 1, "R8 flag set while disabled", v & 1, 1);

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule